// File: doc/BRIEF.md
# Bimodal Branch Predictor with Target-Instruction Buffer

This block predicts branches in the fetch stage of a 32-bit pipeline. A table of 2-bit saturating counters predicts direction. A small direct-mapped branch target buffer holds, for each cached branch or jump, the instruction word found at its target and the address of that target. On a predicted-taken hit, fetch can deliver the target instruction in the same cycle and continue from the word after it, so a taken branch costs no bubble.

The fetch stage drives the fetch PC and reads hit, predicted-taken, the target instruction and the next fetch PC. These outputs come straight from combinational reads of the current state. Branches resolve in decode, and decode writes the actual outcome back through the update port. A state port reads any counter or buffer entry and can overwrite it, so the whole predictor can be saved and restored.

Top module: `bimodal_btb_pred`

## Requirements
- R1: After reset every direction counter holds 2'b10 and no buffer entry is valid. A fetch then sees hit=0, pred_taken=0 and next_pc=fetch_pc+4.
- R2: Counter values are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. An update of kind BEQ (upd_kind=1) or BNE (upd_kind=2) increments the counter when taken and decrements it when not taken. The counter saturates at 11 and at 00.
- R3: The counter index is PC[12:2]. The buffer index is PC[6:2], and the buffer tag is PC[31:7]. A hit requires a valid entry whose tag equals the fetch tag.
- R4: The update writes the buffer entry at its index in two cases: a taken BEQ/BNE, or any J (upd_kind=3) or JAL (upd_kind=4). The written entry holds the tag, the target instruction, the target PC and a jump flag set for J/JAL. A not-taken BEQ/BNE leaves the buffer unchanged.
- R5: Updates of kind JR (5), JALR (6), other (0) or 7 change neither the buffer nor any counter.
- R6: On a hit, tgt_instr is the stored target instruction. pred_taken is 1 when there is a hit and either the entry is a jump or bit 1 of the counter is set.
- R7: next_pc is the stored target PC plus 4 when pred_taken=1, and fetch_pc+4 otherwise.
- R8: An update becomes visible to fetch on the cycle after it is presented, never in the same cycle.
- R9: st_rdata shows counter st_addr in bits [1:0] (upper bits zero) when st_sel=0. When st_sel=1 it shows buffer entry st_addr[4:0] as {valid[88], jump[87], tag[86:62], instr[61:30], target PC[31:2] in [29:0]}. st_we writes st_wdata to the selected location in the same layout. This write wins over an update to the same location in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | PC being fetched |
| upd_valid | input | 1 | Decode presents a resolved control transfer |
| upd_pc | input | 32 | PC of the resolved instruction |
| upd_kind | input | 3 | 0 other, 1 BEQ, 2 BNE, 3 J, 4 JAL, 5 JR, 6 JALR |
| upd_taken | input | 1 | Actual outcome |
| upd_tinstr | input | 32 | Instruction word at the target |
| upd_tpc | input | 32 | Target address |
| st_sel | input | 1 | State port target: 0 counters, 1 buffer |
| st_addr | input | 11 | State port entry index |
| st_we | input | 1 | State port write enable |
| st_wdata | input | 89 | State port write data |
| st_rdata | output | 89 | State port read data |
| hit | output | 1 | Buffer hit for fetch_pc |
| pred_taken | output | 1 | Predicted taken |
| tgt_instr | output | 32 | Cached target instruction |
| next_pc | output | 32 | Next fetch address |

## Verification
A directed phase walks one conditional branch through all four counter states and back. Each step shows that saturation and the hysteresis between weak and strong states are right, and that the cached entry survives not-taken outcomes. Two addresses that share a buffer index but differ in tag tell replacement apart from a tag-blind hit. A jump with its counter forced to 00 tells the jump flag apart from the counter. Indirect jumps and not-taken branches at fresh addresses show that nothing is allocated. A final phase sends random kinds, outcomes and addresses over a few tags, with occasional state-port writes that collide with updates. This exercises aliasing in both tables and the write priority.

// File: rtl/bimodal_btb_pred.sv
module bimodal_btb_pred #(
  parameter int CIDX = 11,
  parameter int BIDX = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [31:0]                    fetch_pc,
  input  logic                           upd_valid,
  input  logic [31:0]                    upd_pc,
  input  logic [2:0]                     upd_kind,
  input  logic                           upd_taken,
  input  logic [31:0]                    upd_tinstr,
  input  logic [31:0]                    upd_tpc,
  input  logic                           st_sel,
  input  logic [CIDX-1:0]                st_addr,
  input  logic                           st_we,
  input  logic [(2+(30-BIDX)+62)-1:0]    st_wdata,
  output logic [(2+(30-BIDX)+62)-1:0]    st_rdata,
  output logic                           hit,
  output logic                           pred_taken,
  output logic [31:0]                    tgt_instr,
  output logic [31:0]                    next_pc
);
  localparam int CN   = 1 << CIDX;
  localparam int BN   = 1 << BIDX;
  localparam int TAGW = 30 - BIDX;
  localparam int EW   = 2 + TAGW + 62;

  logic [1:0]      ctr   [CN];
  logic            bv    [BN];
  logic            bj    [BN];
  logic [TAGW-1:0] btag  [BN];
  logic [31:0]     binst [BN];
  logic [29:0]     btgt  [BN];

  wire [CIDX-1:0] fci  = fetch_pc[CIDX+1:2];
  wire [BIDX-1:0] fbi  = fetch_pc[BIDX+1:2];
  wire [TAGW-1:0] ftag = fetch_pc[31:BIDX+2];
  wire [CIDX-1:0] uci  = upd_pc[CIDX+1:2];
  wire [BIDX-1:0] ubi  = upd_pc[BIDX+1:2];
  wire [TAGW-1:0] utag = upd_pc[31:BIDX+2];
  wire [BIDX-1:0] sbi  = st_addr[BIDX-1:0];
  wire unused_bits = &{1'b0, upd_tpc[1:0]};

  wire is_cond = upd_valid && (upd_kind == 3'd1 || upd_kind == 3'd2);
  wire is_jmp  = upd_valid && (upd_kind == 3'd3 || upd_kind == 3'd4);
  wire alloc   = is_jmp || (is_cond && upd_taken);
  wire st_ctr  = st_we && !st_sel;
  wire st_btb  = st_we && st_sel;

  assign hit        = bv[fbi] && (btag[fbi] == ftag);
  assign pred_taken = hit && (bj[fbi] || ctr[fci][1]);
  assign tgt_instr  = binst[fbi];
  assign next_pc    = pred_taken ? {btgt[fbi], 2'b00} + 32'd4 : fetch_pc + 32'd4;
  assign st_rdata   = st_sel ? {bv[sbi], bj[sbi], btag[sbi], binst[sbi], btgt[sbi]}
                             : {{(EW-2){1'b0}}, ctr[st_addr]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CN; i++) ctr[i] <= 2'b10;
    end else begin
      if (is_cond) begin
        if (upd_taken && ctr[uci] != 2'b11) ctr[uci] <= ctr[uci] + 2'd1;
        else if (!upd_taken && ctr[uci] != 2'b00) ctr[uci] <= ctr[uci] - 2'd1;
      end
      if (st_ctr) ctr[st_addr] <= st_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BN; i++) bv[i] <= 1'b0;
    end else begin
      if (alloc) bv[ubi] <= 1'b1;
      if (st_btb) bv[sbi] <= st_wdata[EW-1];
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      bj[ubi]    <= is_jmp;
      btag[ubi]  <= utag;
      binst[ubi] <= upd_tinstr;
      btgt[ubi]  <= upd_tpc[31:2];
    end
    if (st_btb) begin
      bj[sbi]    <= st_wdata[EW-2];
      btag[sbi]  <= st_wdata[EW-3:62];
      binst[sbi] <= st_wdata[61:30];
      btgt[sbi]  <= st_wdata[29:0];
    end
  end

  // R2
  ctr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cond && upd_taken && ctr[uci] != 2'b11 && !st_ctr) |=> ctr[$past(uci)] == $past(ctr[uci]) + 2'd1);
  // R2
  ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cond && upd_taken && ctr[uci] == 2'b11 && !st_ctr) |=> ctr[$past(uci)] == 2'b11);
  // R2
  ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cond && !upd_taken && ctr[uci] == 2'b00 && !st_ctr) |=> ctr[$past(uci)] == 2'b00);
  // R4
  alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !st_btb) |=> bv[$past(ubi)] && btag[$past(ubi)] == $past(utag));
  // R5
  indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_kind >= 3'd5 && !st_we) |=> bv[$past(ubi)] == $past(bv[ubi]) && ctr[$past(uci)] == $past(ctr[uci]));
  // R4
  nt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cond && !upd_taken && !st_btb) |=> bv[$past(ubi)] == $past(bv[ubi]) && btag[$past(ubi)] == $past(btag[ubi]));
endmodule

// File: tb/bimodal_btb_pred_bench.sv
module bimodal_btb_pred_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] fetch_pc = '0, upd_pc = '0, upd_tinstr = '0, upd_tpc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0, st_sel = 1'b0, st_we = 1'b0;
  logic [2:0] upd_kind = '0;
  logic [10:0] st_addr = '0;
  logic [88:0] st_wdata = '0, st_rdata;
  logic hit, pred_taken;
  logic [31:0] tgt_instr, next_pc;

  int checks = 0, bad = 0;
  int mcnt [2048];
  bit mv [32], mj [32];
  int unsigned mtag [32];
  logic [31:0] mins [32], mtgt [32];

  always #10 clk = ~clk;

  bimodal_btb_pred u_bimodal_btb_pred (.*);

  task automatic chk(string r, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic compare();
    int unsigned bi, ci, tg, sb;
    bit eh, ept;
    logic [31:0] enp;
    bi = (fetch_pc >> 2) % 32; ci = (fetch_pc >> 2) % 2048; tg = fetch_pc >> 7;
    eh  = mv[bi] && mtag[bi] == tg;
    ept = eh && (mj[bi] || mcnt[ci] >= 2);
    enp = ept ? mtgt[bi] + 4 : fetch_pc + 4;
    chk("R3 hit", {95'd0, hit}, {95'd0, eh});
    chk("R6 pred_taken", {95'd0, pred_taken}, {95'd0, ept});
    chk("R7 next_pc", {64'd0, next_pc}, {64'd0, enp});
    if (eh) chk("R6 tgt_instr", {64'd0, tgt_instr}, {64'd0, mins[bi]});
    if (!st_sel) chk("R2/R9 counter read", {7'd0, st_rdata}, 96'(mcnt[st_addr]));
    else begin
      sb = st_addr % 32;
      if (mv[sb]) chk("R9 entry read", {7'd0, st_rdata},
                      {7'd0, 1'b1, mj[sb], 25'(mtag[sb]), mins[sb], mtgt[sb][31:2]});
      else chk("R9 invalid read", {95'd0, st_rdata[88]}, 96'd0);
    end
  endtask

  task automatic model_step();
    int unsigned ci, bi, sb;
    ci = (upd_pc >> 2) % 2048; bi = (upd_pc >> 2) % 32;
    if (upd_valid && (upd_kind == 1 || upd_kind == 2)) begin
      if (upd_taken) mcnt[ci] = (mcnt[ci] == 3) ? 3 : mcnt[ci] + 1;
      else           mcnt[ci] = (mcnt[ci] == 0) ? 0 : mcnt[ci] - 1;
    end
    if (upd_valid && ((upd_kind inside {1, 2} && upd_taken) || upd_kind inside {3, 4})) begin
      mv[bi] = 1; mj[bi] = upd_kind inside {3, 4}; mtag[bi] = upd_pc >> 7;
      mins[bi] = upd_tinstr; mtgt[bi] = upd_tpc & 32'hFFFF_FFFC;
    end
    if (st_we && !st_sel) mcnt[st_addr] = int'(st_wdata[1:0]);
    if (st_we && st_sel) begin
      sb = st_addr % 32;
      mv[sb] = st_wdata[88]; mj[sb] = st_wdata[87]; mtag[sb] = st_wdata[86:62];
      mins[sb] = st_wdata[61:30]; mtgt[sb] = {st_wdata[29:0], 2'b00};
    end
  endtask

  task automatic cyc();
    #2 compare();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    upd_valid = 0; st_we = 0;
  endtask

  task automatic upd(logic [31:0] pc, logic [2:0] k, logic t, logic [31:0] ti, logic [31:0] tp);
    upd_valid = 1; upd_pc = pc; upd_kind = k; upd_taken = t; upd_tinstr = ti; upd_tpc = tp;
  endtask

  function automatic logic [31:0] rpc();
    return (($urandom % 2) << 20) | (($urandom % 4) << 7) | (($urandom % 32) << 2);
  endfunction

  initial begin
    #(20 * 150000);
    bad++; checks++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mcnt[i] = 2;
    for (int i = 0; i < 32; i++) begin mv[i] = 0; mj[i] = 0; mtag[i] = 0; mins[i] = 0; mtgt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    foreach (mcnt[i]) ;
    for (int i = 0; i < 3; i++) begin
      fetch_pc = (i == 0) ? 32'h0 : (i == 1) ? 32'h1000 : 32'h7FFC;
      st_sel = 0; st_addr = fetch_pc[12:2];
      #2;
      chk("R1 hit", {95'd0, hit}, 96'd0);
      chk("R1 counter", {7'd0, st_rdata}, 96'd2);
      chk("R1 next_pc", {64'd0, next_pc}, {64'd0, fetch_pc + 32'd4});
      @(negedge clk);
    end

    fetch_pc = 32'h40; st_addr = 11'h10;
    upd(32'h40, 3'd1, 1, 32'h2002_0005, 32'h200);
    #1 chk("R8 same-cycle hit", {95'd0, hit}, 96'd0);
    cyc();
    #1 chk("R4 hit after taken BEQ", {95'd0, hit}, 96'd1);
    cyc();
    for (int i = 0; i < 5; i++) begin upd(32'h40, 3'd1, 0, 32'h0, 32'h0); cyc(); end
    chk("R4 entry kept after not-taken", {95'd0, hit}, 96'd1);
    cyc();
    for (int i = 0; i < 5; i++) begin upd(32'h40, 3'd2, 1, 32'h2002_0005, 32'h200); cyc(); end

    upd(32'hC0, 3'd3, 1, 32'h0800_0010, 32'h1230);
    cyc();
    fetch_pc = 32'h40;
    #1 chk("R3 tag mismatch after replace", {95'd0, hit}, 96'd0);
    cyc();
    fetch_pc = 32'hC0; st_addr = 11'h30; st_wdata = '0; st_we = 1;
    cyc();
    #1 chk("R6 jump taken with counter 00", {95'd0, pred_taken}, 96'd1);
    chk("R7 jump next_pc", {64'd0, next_pc}, 96'h1234);
    cyc();

    fetch_pc = 32'h300; st_addr = 11'hC0;
    upd(32'h300, 3'd5, 1, 32'h1, 32'h500); cyc();
    upd(32'h300, 3'd6, 1, 32'h1, 32'h500); cyc();
    upd(32'h300, 3'd0, 1, 32'h1, 32'h500); cyc();
    #1 chk("R5 no hit after indirect", {95'd0, hit}, 96'd0);
    chk("R5 counter untouched", {7'd0, st_rdata}, 96'd2);
    cyc();

    fetch_pc = 32'h400;
    upd(32'h400, 3'd2, 0, 32'h1, 32'h600); cyc();
    #1 chk("R4 no alloc on not-taken", {95'd0, hit}, 96'd0);
    cyc();

    fetch_pc = 32'h108C; st_sel = 1; st_addr = 11'd3; st_we = 1;
    st_wdata = {1'b1, 1'b0, 25'h21, 32'hDEAD_BEEF, 30'h100};
    cyc();
    #1 chk("R9 loaded entry hit", {95'd0, hit}, 96'd1);
    chk("R9 loaded instr", {64'd0, tgt_instr}, 96'hDEAD_BEEF);
    cyc();

    fetch_pc = 32'h800; st_sel = 0; st_addr = 11'h200; st_we = 1; st_wdata = '0;
    upd(32'h800, 3'd1, 1, 32'h7, 32'h900); cyc();
    #1 chk("R9 write wins", {7'd0, st_rdata}, 96'd0);
    cyc();

    for (int n = 0; n < 3000; n++) begin
      fetch_pc = ($urandom % 4 == 0) ? upd_pc : rpc();
      if ($urandom % 3 != 0) upd(rpc(), 3'($urandom % 8), 1'($urandom % 2), $urandom, $urandom);
      st_sel = 1'($urandom % 2);
      st_addr = ($urandom % 2) ? upd_pc[12:2] : fetch_pc[12:2];
      if ($urandom % 10 == 0) begin
        st_we = 1;
        st_wdata = {1'($urandom % 2), 1'($urandom % 2), 25'($urandom % 4 | (($urandom % 2) << 6)),
                    32'($urandom), 30'($urandom)};
        if (!st_sel) st_wdata = {87'd0, 2'($urandom)};
      end
      cyc();
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule